// File: doc/BRIEF.md
# Control Register Move Unit

This unit sits beside the execute stage of a 32-bit processor core. It decodes and carries out the privileged two-word instruction that moves a value between a general register and one of the core's control registers. The opcode word and the extension word come from the fetch stage. When the execute strobe is given, the unit does one of two things. It reads a general data or address register through a simple read port and updates a control register at the next clock edge. Otherwise it places a control register's value on the register-file write port in the same cycle.

The unit also holds the vector base register, which relocates the exception vector table. Given a vector number, it supplies the address of that vector's table entry: the vector number times four, plus the base. The base always has its low ten bits clear. A control-register code that the unit does not know raises an illegal-instruction flag, and nothing changes state.

Top module: `ctlreg_move_unit`

## Requirements
- R1: The instruction is recognised when opcode bits 15:1 equal 0x4E7A >> 1, that is, opcode 0x4E7A or 0x4E7B. With `exec_i` high on a recognised opcode, `done_o` is high in the same cycle. Any other opcode gives `done_o`, `illegal_o` and `rf_wr_en_o` all low and changes no state.
- R2: Opcode bit 0 selects the direction. With 1, the general register selected by the extension word is read and the control register is loaded at the next clock edge, and `rf_wr_en_o` stays low. With 0, `rf_wr_en_o` is high in the same cycle and carries the control register's value.
- R3: Extension bit 15 selects the register class (1 = address, 0 = data), and bits 14:12 select the register number. Both the read port and the write port use these fields.
- R4: Extension bits 11:0 select the control register: 0x000 source function code, 0x001 destination function code, 0x800 user stack pointer, 0x801 vector base.
- R5: Any other control-register code gives `illegal_o` high together with `done_o`, keeps `rf_wr_en_o` low, and leaves every control register unchanged.
- R6: A write to the vector base stores the 32-bit operand with bits 9:0 cleared.
- R7: Moves to and from the user stack pointer and the vector base transfer all 32 bits.
- R8: The two function code registers are 3 bits wide. A write keeps operand bits 2:0, and a read returns the value zero-extended to 32 bits.
- R9: `vec_addr_o` equals `vec_num_i` times 4 plus the vector base. It is combinational from the registered base, so it reflects a base write from the cycle after that write. The bus-error vector is number 2.
- R10: After reset, all four control registers are zero, so `vec_addr_o` equals `vec_num_i` times 4.
- R11: With `exec_i` low, `done_o`, `illegal_o` and `rf_wr_en_o` are low and no control register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | One-cycle execute strobe |
| opcode_i | input | 16 | First instruction word |
| ext_i | input | 16 | Extension word |
| rf_rd_cls_o | output | 1 | Read port register class (1 = address) |
| rf_rd_idx_o | output | 3 | Read port register number |
| rf_rd_data_i | input | 32 | Read port data |
| rf_wr_en_o | output | 1 | Register-file write enable |
| rf_wr_cls_o | output | 1 | Write port register class |
| rf_wr_idx_o | output | 3 | Write port register number |
| rf_wr_data_o | output | 32 | Write port data |
| done_o | output | 1 | Instruction completed this cycle |
| illegal_o | output | 1 | Unknown control-register code |
| vec_num_i | input | 8 | Exception vector number |
| vec_addr_o | output | 32 | Vector table entry address |

## Verification
The bench writes a base value whose low ten bits are all ones. It then checks both the read-back value and the vector addresses for vector 2 and vector 255. A design that skipped the mask would produce fetch addresses off by up to 1023 bytes, and a design that forgot the base would fetch from the fixed low table. Illegal codes are issued in both directions right after valid writes, and the registers are then read back. A design that let an illegal code through would either corrupt a register or raise a spurious register-file write. The function code registers receive operands with high bits set, so a missing truncation shows up on read-back. Non-matching opcodes and idle cycles that carry a write opcode are checked for silence, which catches a loose opcode match or a missing strobe qualifier.

// File: rtl/ctlmv_pkg.sv
package ctlmv_pkg;

    localparam int XLEN_DEF  = 32;
    localparam int FC_W_DEF  = 3;
    localparam int ALIGN_DEF = 10;
    localparam int VEC_W_DEF = 8;
    localparam int IDX_W_DEF = 3;
    localparam int CODE_W    = 12;

    localparam logic [CODE_W-1:0] CODE_SFC = 12'h000;
    localparam logic [CODE_W-1:0] CODE_DFC = 12'h001;
    localparam logic [CODE_W-1:0] CODE_USP = 12'h800;
    localparam logic [CODE_W-1:0] CODE_VBR = 12'h801;

    // opcode bits 15:1 that identify the instruction
    localparam logic [14:0] OPC_PATTERN = 15'h273D;

    typedef enum logic [1:0] {
        SEL_SFC = 2'd0,
        SEL_DFC = 2'd1,
        SEL_USP = 2'd2,
        SEL_VBR = 2'd3
    } crsel_e;

    typedef struct packed {
        logic   hit;
        logic   to_ctrl;
        logic   code_ok;
        crsel_e sel;
        logic   cls;
        logic [IDX_W_DEF-1:0] idx;
    } dec_t;

endpackage

// File: rtl/ctlmv_decode.sv
module ctlmv_decode
    import ctlmv_pkg::*;
(
    input  logic [15:0] opcode_i,
    input  logic [15:0] ext_i,
    output dec_t        dec_o
);

    always_comb begin
        dec_o         = '0;
        dec_o.hit     = (opcode_i[15:1] == OPC_PATTERN);
        dec_o.to_ctrl = opcode_i[0];
        dec_o.cls     = ext_i[15];
        dec_o.idx     = ext_i[14:12];
        dec_o.code_ok = 1'b1;
        unique case (ext_i[CODE_W-1:0])
            CODE_SFC: dec_o.sel = SEL_SFC;
            CODE_DFC: dec_o.sel = SEL_DFC;
            CODE_USP: dec_o.sel = SEL_USP;
            CODE_VBR: dec_o.sel = SEL_VBR;
            default: begin
                dec_o.sel     = SEL_SFC;
                dec_o.code_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ctlmv_regs.sv
module ctlmv_regs
    import ctlmv_pkg::*;
#(
    parameter int XLEN  = XLEN_DEF,
    parameter int FC_W  = FC_W_DEF,
    parameter int ALIGN = ALIGN_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  crsel_e          sel_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] rdata_o,
    output logic [XLEN-1:0] vbr_o
);

    localparam logic [XLEN-1:0] ALIGN_MASK = ~((XLEN'(1) << ALIGN) - XLEN'(1));

    typedef struct packed {
        logic [FC_W-1:0] sfc;
        logic [FC_W-1:0] dfc;
        logic [XLEN-1:0] usp;
        logic [XLEN-1:0] vbr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            unique case (sel_i)
                SEL_SFC: st_d.sfc = wdata_i[FC_W-1:0];
                SEL_DFC: st_d.dfc = wdata_i[FC_W-1:0];
                SEL_USP: st_d.usp = wdata_i;
                SEL_VBR: st_d.vbr = wdata_i & ALIGN_MASK;
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (sel_i)
            SEL_SFC: rdata_o = XLEN'(st_q.sfc);
            SEL_DFC: rdata_o = XLEN'(st_q.dfc);
            SEL_USP: rdata_o = st_q.usp;
            SEL_VBR: rdata_o = st_q.vbr;
            default: rdata_o = '0;
        endcase
    end

    assign vbr_o = st_q.vbr;

endmodule

// File: rtl/ctlmv_vecgen.sv
module ctlmv_vecgen #(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8
) (
    input  logic [XLEN-1:0]  vbr_i,
    input  logic [VEC_W-1:0] vec_num_i,
    output logic [XLEN-1:0]  vec_addr_o
);

    localparam int OFF_W = VEC_W + 2;

    logic [XLEN-1:0] offset;

    always_comb begin
        offset             = '0;
        offset[OFF_W-1:0]  = {vec_num_i, 2'b00};
        vec_addr_o         = vbr_i + offset;
    end

endmodule

// File: rtl/ctlreg_move_unit.sv
module ctlreg_move_unit
    import ctlmv_pkg::*;
#(
    parameter int XLEN  = XLEN_DEF,
    parameter int FC_W  = FC_W_DEF,
    parameter int ALIGN = ALIGN_DEF,
    parameter int VEC_W = VEC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_i,
    input  logic [15:0]      opcode_i,
    input  logic [15:0]      ext_i,
    output logic             rf_rd_cls_o,
    output logic [2:0]       rf_rd_idx_o,
    input  logic [XLEN-1:0]  rf_rd_data_i,
    output logic             rf_wr_en_o,
    output logic             rf_wr_cls_o,
    output logic [2:0]       rf_wr_idx_o,
    output logic [XLEN-1:0]  rf_wr_data_o,
    output logic             done_o,
    output logic             illegal_o,
    input  logic [VEC_W-1:0] vec_num_i,
    output logic [XLEN-1:0]  vec_addr_o
);

    dec_t            dec;
    logic            ctl_we;
    logic [XLEN-1:0] ctl_rdata;
    logic [XLEN-1:0] vbr;
    logic            active;

    ctlmv_decode u_dec (
        .opcode_i (opcode_i),
        .ext_i    (ext_i),
        .dec_o    (dec)
    );

    assign active = exec_i & dec.hit;
    assign ctl_we = active & dec.code_ok & dec.to_ctrl;

    ctlmv_regs #(.XLEN(XLEN), .FC_W(FC_W), .ALIGN(ALIGN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ctl_we),
        .sel_i   (dec.sel),
        .wdata_i (rf_rd_data_i),
        .rdata_o (ctl_rdata),
        .vbr_o   (vbr)
    );

    ctlmv_vecgen #(.XLEN(XLEN), .VEC_W(VEC_W)) u_vec (
        .vbr_i      (vbr),
        .vec_num_i  (vec_num_i),
        .vec_addr_o (vec_addr_o)
    );

    assign rf_rd_cls_o  = dec.cls;
    assign rf_rd_idx_o  = dec.idx;
    assign rf_wr_cls_o  = dec.cls;
    assign rf_wr_idx_o  = dec.idx;
    assign rf_wr_data_o = ctl_rdata;
    assign rf_wr_en_o   = active & dec.code_ok & ~dec.to_ctrl;
    assign done_o       = active;
    assign illegal_o    = active & ~dec.code_ok;

endmodule

// File: rtl/ctlmv_chk.sv
module ctlmv_chk #(
    parameter int XLEN  = 32,
    parameter int ALIGN = 10,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exec_i,
    input logic [15:0]      opcode_i,
    input logic [15:0]      ext_i,
    input logic             rf_wr_en_o,
    input logic             done_o,
    input logic             illegal_o,
    input logic [VEC_W-1:0] vec_num_i,
    input logic [XLEN-1:0]  vec_addr_o
);

    logic base_write;
    assign base_write = exec_i && done_o && !illegal_o && opcode_i[0]
                        && (ext_i[11:0] == 12'h801);

    // R5
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (done_o && !rf_wr_en_o));

    // R2
    write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en_o |-> (exec_i && done_o && !opcode_i[0]));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |-> (!done_o && !illegal_o && !rf_wr_en_o));

    // R6
    vec_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_addr_o[ALIGN-1:0] == ALIGN'({vec_num_i, 2'b00}));

    // R9
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !base_write |=> $stable(vec_addr_o[XLEN-1:ALIGN]));

endmodule

bind ctlreg_move_unit ctlmv_chk #(.XLEN(XLEN), .ALIGN(ALIGN), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_i     (exec_i),
    .opcode_i   (opcode_i),
    .ext_i      (ext_i),
    .rf_wr_en_o (rf_wr_en_o),
    .done_o     (done_o),
    .illegal_o  (illegal_o),
    .vec_num_i  (vec_num_i),
    .vec_addr_o (vec_addr_o)
);

// File: tb/ctlreg_move_unit_tb.sv
module ctlreg_move_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [15:0] opcode_i = '0;
    logic [15:0] ext_i = '0;
    logic        rf_rd_cls_o;
    logic [2:0]  rf_rd_idx_o;
    logic [31:0] rf_rd_data_i = '0;
    logic        rf_wr_en_o;
    logic        rf_wr_cls_o;
    logic [2:0]  rf_wr_idx_o;
    logic [31:0] rf_wr_data_o;
    logic        done_o;
    logic        illegal_o;
    logic [7:0]  vec_num_i = '0;
    logic [31:0] vec_addr_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ctlreg_move_unit u_dut (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .opcode_i(opcode_i), .ext_i(ext_i),
        .rf_rd_cls_o(rf_rd_cls_o), .rf_rd_idx_o(rf_rd_idx_o), .rf_rd_data_i(rf_rd_data_i),
        .rf_wr_en_o(rf_wr_en_o), .rf_wr_cls_o(rf_wr_cls_o), .rf_wr_idx_o(rf_wr_idx_o),
        .rf_wr_data_o(rf_wr_data_o), .done_o(done_o), .illegal_o(illegal_o),
        .vec_num_i(vec_num_i), .vec_addr_o(vec_addr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one instruction at the falling edge, sample before the rising edge.
    task automatic issue(input logic ex, input logic [15:0] op, input logic [15:0] ext,
                         input logic [31:0] rd);
        @(negedge clk);
        exec_i = ex; opcode_i = op; ext_i = ext; rf_rd_data_i = rd;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        exec_i = 1'b0; opcode_i = '0; ext_i = '0; rf_rd_data_i = '0;
        #1;
    endtask

    // {opcode, ext, rd_data, exp_wen, exp_illegal, exp_wdata}
    localparam int TW = 98;
    localparam int NV = 12;
    localparam logic [TW-1:0] VECS [NV] = '{
        {16'h4E7B, 16'h1801, 32'h123456FF, 1'b0, 1'b0, 32'h0},        // R6 base write from D1
        {16'h4E7A, 16'hB801, 32'h0,        1'b1, 1'b0, 32'h12345400}, // R6 read to A3
        {16'h4E7B, 16'h8800, 32'hDEADBEEF, 1'b0, 1'b0, 32'h0},        // R7 usp from A0
        {16'h4E7A, 16'h7800, 32'h0,        1'b1, 1'b0, 32'hDEADBEEF}, // R7 usp to D7
        {16'h4E7B, 16'h2000, 32'hFFFFFFFD, 1'b0, 1'b0, 32'h0},        // R8 sfc from D2
        {16'h4E7A, 16'h0000, 32'h0,        1'b1, 1'b0, 32'h00000005}, // R8 sfc to D0
        {16'h4E7B, 16'h3001, 32'h0000000A, 1'b0, 1'b0, 32'h0},        // R8 dfc from D3
        {16'h4E7A, 16'hE001, 32'h0,        1'b1, 1'b0, 32'h00000002}, // R8 dfc to A6
        {16'h4E7B, 16'h1802, 32'hFFFFFFFF, 1'b0, 1'b1, 32'h0},        // R5 bad code write
        {16'h4E7A, 16'h0002, 32'h0,        1'b0, 1'b1, 32'h0},        // R5 bad code read
        {16'h4E7A, 16'h4801, 32'h0,        1'b1, 1'b0, 32'h12345400}, // R5 base intact
        {16'h4E7A, 16'hD800, 32'h0,        1'b1, 1'b0, 32'hDEADBEEF}  // R5 usp intact
    };

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10 reset state
        idle();
        vec_num_i = 8'd2; #1;
        check("R10 reset bus-error vector address", vec_addr_o, 32'h8);
        check("R11 idle done", {31'b0, done_o}, 32'h0);
        issue(1'b1, 16'h4E7A, 16'h0801, 32'h0);
        check("R10 reset base readback", rf_wr_data_o, 32'h0);
        issue(1'b1, 16'h4E7A, 16'h0800, 32'h0);
        check("R10 reset usp readback", rf_wr_data_o, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] op, ext;
            logic [31:0] rd, wd;
            logic wen, ill;
            {op, ext, rd, wen, ill, wd} = VECS[i];
            issue(1'b1, op, ext, rd);
            check("R1 done", {31'b0, done_o}, 32'h1);
            check("R2 write enable", {31'b0, rf_wr_en_o}, {31'b0, wen});
            check("R5 illegal", {31'b0, illegal_o}, {31'b0, ill});
            if (wen) begin
                check("R4 readback data", rf_wr_data_o, wd);
                check("R3 write port reg", {28'b0, rf_wr_cls_o, rf_wr_idx_o}, {28'b0, ext[15:12]});
            end
            if (op[0])
                check("R3 read port reg", {28'b0, rf_rd_cls_o, rf_rd_idx_o}, {28'b0, ext[15:12]});
        end

        // R9 vector addresses follow the masked base
        idle();
        vec_num_i = 8'd2; #1;
        check("R9 bus-error vector with base", vec_addr_o, 32'h12345408);
        vec_num_i = 8'hFF; #1;
        check("R9 top vector with base", vec_addr_o, 32'h123457FC);

        // R9 update seen the cycle after a base write
        issue(1'b1, 16'h4E7B, 16'h0801, 32'h00000400);
        vec_num_i = 8'd3; #1;
        check("R9 address before edge", vec_addr_o, 32'h1234540C);
        idle();
        check("R9 address after base write", vec_addr_o, 32'h0000040C);

        // R1 non-matching opcodes are silent and change nothing
        issue(1'b1, 16'h4E71, 16'h0801, 32'hFFFFFFFF);
        check("R1 foreign opcode done", {29'b0, done_o, illegal_o, rf_wr_en_o}, 32'h0);
        issue(1'b1, 16'h5E7B, 16'h0801, 32'hFFFFFFFF);
        check("R1 wrong top nibble done", {29'b0, done_o, illegal_o, rf_wr_en_o}, 32'h0);

        // R11 write opcode without strobe has no effect
        issue(1'b0, 16'h4E7B, 16'h0801, 32'hFFFFFC00);
        check("R11 no strobe outputs", {29'b0, done_o, illegal_o, rf_wr_en_o}, 32'h0);
        idle();
        check("R11 base unchanged", vec_addr_o, 32'h0000040C);
        issue(1'b1, 16'h4E7A, 16'h0801, 32'h0);
        check("R1 base unchanged after foreign opcodes", rf_wr_data_o, 32'h00000400);

        // R7 high usp bit travels through
        issue(1'b1, 16'h4E7B, 16'h9800, 32'h80000001);
        issue(1'b1, 16'h4E7A, 16'h1800, 32'h0);
        check("R7 usp full width", rf_wr_data_o, 32'h80000001);

        idle();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule